// File: doc/BRIEF.md
# DMA Channel Allocator and Interrupt Controller

This block is the control and status front end of a DMA engine with eight channels that may all run at once. It keeps a busy flag per channel and offers software the lowest-numbered idle channel. Every channel has equal standing; there is no programmable priority. Software reads the offered index, then launches the channel by writing its bit to the launch register. Reading the index reserves nothing: a channel is taken only when it is launched. When every channel is busy, the index reads as 8, and software keeps polling until a channel frees. The per-channel transfer engines are outside the block. They appear here only as one-cycle "done" and "fault" pulses, and the block returns a one-cycle start pulse to each engine.

Done and fault pulses are latched into two status words, one bit per channel. The pending register reports the lowest channel with any latched event, so software services interrupts from the least-significant set bit upward. Each status word has its own write-one-to-clear register. A global enable bit must be set before any channel can be launched or can record an event. The single interrupt line is the OR of all latched events, gated by that enable.

The register interface uses a 3-bit word address, a write strobe and 32-bit data. Reads are combinational and have no side effects.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following are zero: the enable bit, every busy flag, both status words, `irq` and `chan_start`. The offered free index reads 0 and the pending index (address 7) reads 8.
- R2: Bit 0 of address 0 is the global enable; it is readable and writable. While it is 0, a write to the launch register (address 2) leaves every busy flag clear and produces no `chan_start` pulse.
- R3: While the block is enabled, a write to address 2 launches channels. For each set bit of the written data whose channel is idle, the busy flag is set on the next clock edge, and `chan_start` pulses that bit high for exactly that one following cycle. Set bits for channels that are already busy are ignored.
- R4: Address 1 reads the lowest idle channel index in bits [3:0], or 8 if all channels are busy, and the busy mask in bits [23:16]. Reading it changes no state.
- R5: A `chan_done` or `chan_fault` pulse on a channel clears that channel's busy flag on the next edge, whether or not the block is enabled.
- R6: While the block is enabled, a `chan_done` pulse sets the channel's bit in the done status (address 3), and a `chan_fault` pulse sets it in the fault status (address 4). Pulses that arrive while the block is disabled are not recorded.
- R7: Writing a mask to address 5 clears the done status bits under the mask; writing a mask to address 6 does the same for the fault status. Bits outside the mask, and the other status word, are unchanged.
- R8: If a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R9: Address 7 reads the lowest channel index whose done or fault status bit is set, or 8 if none is set.
- R10: `irq` is high exactly when the enable bit is 1 and at least one status bit is set. Clearing the enable bit masks `irq` but keeps the latched status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| chan_done | input | 8 | One-cycle terminal-count pulse per channel |
| chan_fault | input | 8 | One-cycle error pulse per channel |
| chan_start | output | 8 | One-cycle launch pulse per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench launches overlapping masks that include channels already running. A design that re-launched a busy channel would emit a second start pulse, and one that scanned from the wrong end would offer the wrong free index. The bench fills every channel to reach the "none free" code of 8, then frees channels out of order to check that the offered index moves back to the lowest gap. It drives a clear and an event into the same status bit in one cycle; a design where the clear wins would lose that interrupt. It also sends an event while the block is disabled: a design that leaked it into the status would show it there, while one that failed to free the channel would keep it marked busy.

// File: rtl/dma_chan_ctrl_pkg.sv
package dma_chan_ctrl_pkg;

    localparam int CH_COUNT = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int BUSY_LSB = 16;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL      = 3'd0,
        RA_ALLOC     = 3'd1,
        RA_LAUNCH    = 3'd2,
        RA_DONE_ST   = 3'd3,
        RA_FAULT_ST  = 3'd4,
        RA_DONE_CLR  = 3'd5,
        RA_FAULT_CLR = 3'd6,
        RA_PEND      = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        reg_addr_e         addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic int idx_width(input int n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/dma_lowest_one.sv
module dma_lowest_one #(
    parameter int N  = 8,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = IW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_busy_track.sv
module dma_busy_track #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch_en,
    input  logic [N-1:0] launch_mask,
    input  logic [N-1:0] retire,
    output logic [N-1:0] busy,
    output logic [N-1:0] start_pulse
);
    logic [N-1:0] start_ok;

    assign start_ok = launch_en ? (launch_mask & ~busy) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= '0;
            start_pulse <= '0;
        end else begin
            busy        <= (busy & ~retire) | start_ok;
            start_pulse <= start_ok;
        end
    end

    // R3: a launched idle channel is busy on the following cycle
    assert_launch_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (|start_ok) |=> ((busy & $past(start_ok)) == $past(start_ok)));

    // R3: start pulse appears only for channels that were idle
    assert_start_idle_only_R3: assert property (@(posedge clk) disable iff (rst)
        (|start_pulse) |-> (($past(busy) & start_pulse) == '0));

    // R5: a retired channel not relaunched is free next cycle
    assert_retire_frees_R5: assert property (@(posedge clk) disable iff (rst)
        (|(retire & ~start_ok)) |=> ((busy & $past(retire & ~start_ok)) == '0));
endmodule

// File: rtl/dma_event_status.sv
module dma_event_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] ev,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] stat
);
    logic [N-1:0] ev_eff;
    logic [N-1:0] clr_eff;

    assign ev_eff  = en ? ev : '0;
    assign clr_eff = clr_wr ? clr_mask : '0;

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)             bit_q <= 1'b0;
            else if (ev_eff[g])  bit_q <= 1'b1;
            else if (clr_eff[g]) bit_q <= 1'b0;
        end
        assign stat[g] = bit_q;
    end

    // R8: an accepted event is visible next cycle even under a clear
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (|ev_eff) |=> ((stat & $past(ev_eff)) == $past(ev_eff)));

    // R7: cleared bits without a fresh event are zero next cycle
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (|(clr_eff & ~ev_eff)) |=> ((stat & $past(clr_eff & ~ev_eff)) == '0));

    // R6: with no event and no clear the status holds
    assert_status_holds_R6: assert property (@(posedge clk) disable iff (rst)
        ((ev_eff == '0) && (clr_eff == '0)) |=> $stable(stat));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_ctrl_pkg::*;
#(
    parameter int NCH = CH_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NCH-1:0]    chan_done,
    input  logic [NCH-1:0]    chan_fault,
    output logic [NCH-1:0]    chan_start,
    output logic              irq
);
    localparam int IW = idx_width(NCH);

    reg_req_t       req;
    logic           enable_q;
    logic [NCH-1:0] busy;
    logic [NCH-1:0] done_st;
    logic [NCH-1:0] fault_st;
    logic [NCH-1:0] pend;
    logic [IW-1:0]  free_idx;
    logic [IW-1:0]  pend_idx;

    assign req.wr    = reg_wr;
    assign req.addr  = reg_addr_e'(reg_addr);
    assign req.wdata = reg_wdata;

    always_ff @(posedge clk) begin
        if (rst)                                enable_q <= 1'b0;
        else if (req.wr && req.addr == RA_CTRL) enable_q <= req.wdata[0];
    end

    dma_busy_track #(.N(NCH)) u_busy (
        .clk         (clk),
        .rst         (rst),
        .launch_en   (req.wr && req.addr == RA_LAUNCH && enable_q),
        .launch_mask (req.wdata[NCH-1:0]),
        .retire      (chan_done | chan_fault),
        .busy        (busy),
        .start_pulse (chan_start)
    );

    dma_event_status #(.N(NCH)) u_done_st (
        .clk      (clk),
        .rst      (rst),
        .en       (enable_q),
        .ev       (chan_done),
        .clr_wr   (req.wr && req.addr == RA_DONE_CLR),
        .clr_mask (req.wdata[NCH-1:0]),
        .stat     (done_st)
    );

    dma_event_status #(.N(NCH)) u_fault_st (
        .clk      (clk),
        .rst      (rst),
        .en       (enable_q),
        .ev       (chan_fault),
        .clr_wr   (req.wr && req.addr == RA_FAULT_CLR),
        .clr_mask (req.wdata[NCH-1:0]),
        .stat     (fault_st)
    );

    assign pend = done_st | fault_st;

    dma_lowest_one #(.N(NCH), .IW(IW)) u_free_pick (
        .vec (~busy),
        .idx (free_idx)
    );

    dma_lowest_one #(.N(NCH), .IW(IW)) u_pend_pick (
        .vec (pend),
        .idx (pend_idx)
    );

    assign irq = enable_q && (|pend);

    always_comb begin
        reg_rdata = '0;
        unique case (req.addr)
            RA_CTRL:     reg_rdata[0] = enable_q;
            RA_ALLOC: begin
                reg_rdata[IW-1:0]                = free_idx;
                reg_rdata[BUSY_LSB +: NCH]       = busy;
            end
            RA_DONE_ST:  reg_rdata[NCH-1:0] = done_st;
            RA_FAULT_ST: reg_rdata[NCH-1:0] = fault_st;
            RA_PEND:     reg_rdata[IW-1:0]  = pend_idx;
            default:     reg_rdata = '0;
        endcase
    end

    // R4: the offered channel is idle, and all-busy reports NCH
    assert_free_is_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (free_idx != IW'(NCH)) |-> (((busy >> free_idx) & NCH'(1)) == '0));
    assert_none_free_R4: assert property (@(posedge clk) disable iff (rst)
        (&busy) |-> (free_idx == IW'(NCH)));

    // R9: reported pending index points at a set status bit
    assert_pend_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (pend_idx != IW'(NCH)) |-> (((pend >> pend_idx) & NCH'(1)) != '0));

    // R10: interrupt never raised while disabled
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> enable_q);

    // R2: no launch pulse follows a disabled cycle
    assert_no_launch_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!enable_q) |=> (chan_start == '0));
endmodule

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/10ps
module dma_chan_ctrl_bench;
    import dma_chan_ctrl_pkg::*;

    localparam int SEL_RD  = 0;
    localparam int SEL_IRQ = 1;
    localparam int SEL_STA = 2;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  chan_done = '0;
    logic [7:0]  chan_fault = '0;
    logic [7:0]  chan_start;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    exp_item_t sb_q[$];
    event sb_ev;

    always #4 clk = ~clk;

    dma_chan_ctrl u_dma_chan_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_done(chan_done), .chan_fault(chan_fault),
        .chan_start(chan_start), .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    SEL_IRQ: act = {31'd0, irq};
                    SEL_STA: act = {24'd0, chan_start};
                    default: act = reg_rdata;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int sel, input logic [2:0] addr,
                              input logic [31:0] exp, input string tag);
        exp_item_t it;
        reg_addr = addr;
        #0.1;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> sb_ev;
        #0.1;
    endtask

    task automatic reg_write(input logic [2:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] d, input logic [7:0] f);
        @(negedge clk);
        chan_done = d; chan_fault = f;
        @(negedge clk);
        chan_done = '0; chan_fault = '0;
    endtask

    function automatic logic [31:0] alloc_word(input logic [7:0] b, input int idx);
        return ({24'd0, b} << 16) | idx;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_val(SEL_RD, 3'd0, 32'd0, "R1 enable after reset");
        expect_val(SEL_RD, 3'd1, 32'd0, "R1 alloc after reset");
        expect_val(SEL_RD, 3'd7, 32'd8, "R1 pending index after reset");
        expect_val(SEL_IRQ, 3'd0, 32'd0, "R1 irq after reset");
        expect_val(SEL_STA, 3'd0, 32'd0, "R1 start after reset");

        reg_write(3'd2, 32'h01);
        expect_val(SEL_STA, 3'd0, 32'd0, "R2 no start while disabled");
        expect_val(SEL_RD, 3'd1, 32'd0, "R2 no busy while disabled");

        reg_write(3'd0, 32'h1);
        expect_val(SEL_RD, 3'd0, 32'd1, "R2 enable readback");

        reg_write(3'd2, 32'h05);
        expect_val(SEL_STA, 3'd0, 32'h05, "R3 start pulse");
        expect_val(SEL_RD, 3'd1, alloc_word(8'h05, 1), "R4 alloc after launch");
        expect_val(SEL_RD, 3'd1, alloc_word(8'h05, 1), "R4 reread no side effect");
        @(negedge clk);
        expect_val(SEL_STA, 3'd0, 32'h00, "R3 start lasts one cycle");

        reg_write(3'd2, 32'h07);
        expect_val(SEL_STA, 3'd0, 32'h02, "R3 busy channels ignored");
        expect_val(SEL_RD, 3'd1, alloc_word(8'h07, 3), "R4 alloc lowest gap");

        reg_write(3'd2, 32'hF8);
        expect_val(SEL_RD, 3'd1, alloc_word(8'hFF, 8), "R4 none free reads 8");

        pulse(8'h04, 8'h00);
        expect_val(SEL_RD, 3'd3, 32'h04, "R6 done status set");
        expect_val(SEL_RD, 3'd1, alloc_word(8'hFB, 2), "R5 done frees channel");
        expect_val(SEL_IRQ, 3'd0, 32'd1, "R10 irq raised");
        expect_val(SEL_RD, 3'd7, 32'd2, "R9 pending index");

        pulse(8'h00, 8'h20);
        expect_val(SEL_RD, 3'd4, 32'h20, "R6 fault status set");
        expect_val(SEL_RD, 3'd1, alloc_word(8'hDB, 2), "R5 fault frees channel");

        pulse(8'h40, 8'h00);
        expect_val(SEL_RD, 3'd3, 32'h44, "R6 done status accumulates");
        expect_val(SEL_RD, 3'd7, 32'd2, "R9 lowest of several");

        reg_write(3'd5, 32'h04);
        expect_val(SEL_RD, 3'd3, 32'h40, "R7 done clear under mask");
        expect_val(SEL_RD, 3'd4, 32'h20, "R7 fault untouched");
        expect_val(SEL_RD, 3'd7, 32'd5, "R9 index moves up");

        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h20; chan_fault = 8'h20;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; chan_fault = '0;
        expect_val(SEL_RD, 3'd4, 32'h20, "R8 event beats clear");

        reg_write(3'd0, 32'h0);
        expect_val(SEL_IRQ, 3'd0, 32'd0, "R10 irq masked when disabled");
        expect_val(SEL_RD, 3'd3, 32'h40, "R10 status kept when disabled");
        pulse(8'h00, 8'h02);
        expect_val(SEL_RD, 3'd4, 32'h20, "R6 event ignored when disabled");
        expect_val(SEL_RD, 3'd1, alloc_word(8'h99, 1), "R5 frees while disabled");

        reg_write(3'd0, 32'h1);
        expect_val(SEL_IRQ, 3'd0, 32'd1, "R10 irq back on enable");
        reg_write(3'd5, 32'hFF);
        reg_write(3'd6, 32'hFF);
        expect_val(SEL_RD, 3'd7, 32'd8, "R9 none pending reads 8");
        expect_val(SEL_IRQ, 3'd0, 32'd0, "R10 irq low when clear");

        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule